// File: doc/BRIEF.md
# Packed Half-Precision to 8-Bit Float Converter

The block turns four IEEE half-precision numbers into four compact 8-bit floating-point bytes. Each byte is sign-magnitude: one sign bit, a 4-bit exponent and a 3-bit mantissa. The halves arrive as one 64-bit input beat that holds two 32-bit words. Each word carries two halves. The result leaves as one 32-bit word of four bytes. The byte's exponent and mantissa are a contiguous slice of the half, so the block does no exponent re-biasing. Rounding to nearest is done by adding half of one output LSB below that slice. Each 32-bit word is rounded with a single wide adder, and a mask stops a carry from crossing between its two lanes.

The input side and the output side are valid/ready streams, separated by one register stage. A beat is taken on any clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. This lets the block sustain one beat per cycle. While `out_valid` is high and `out_ready` is low, the output register keeps its contents and `in_ready` stays low.

A half is in scope when its magnitude bits [14:0] are below 0x3FC0. That is the same as a value below 1.9375 with the top exponent bit clear. For halves outside that range (NaN, infinity, large values) the output byte is don't-care.

Top module: `half_to_f8_packer`

## Requirements
- R1: Bit 7 of every output byte equals bit 15 (the sign) of the half in that lane, for every input, in scope or not.
- R2: A half whose bits [6:0] are zero converts exactly: the output bits [6:0] equal half bits [13:7] (4 exponent bits above 3 mantissa bits).
- R3: For every in-scope half, the output magnitude is an 8-bit code whose value lies at minimum absolute distance from the half's value.
- R4: An in-scope half that lies exactly halfway between two codes (bits [6:0] equal 0x40) rounds to the code of larger magnitude, i.e. to half bits [13:7] plus one.
- R5: Lane order: `in_data[15:0]` is lane 0, `[31:16]` lane 1, `[47:32]` lane 2, `[63:48]` lane 3, and output byte k (`out_data[8k+7:8k]`) is lane k.
- R6: The result of a lane does not depend on the other lanes' contents, even when a neighbouring lane produces a rounding carry out of its top code.
- R7: Expanding any of the 256 byte codes b to the half {b[7], 0, b[6:0], 7'b0} and converting it back returns b.
- R8: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. A beat is taken only when `in_valid` and `in_ready` are both high.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` holds its value.
- R10: While `rst_n` is low and after it rises, `out_valid` is low until the first beat is taken.
- R11: A beat taken at a clock edge is presented on `out_valid`/`out_data` right after that edge. Once the consumer takes it with no new beat arriving, `out_valid` falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Producer holds a beat of four halves |
| in_ready | output | 1 | Block can take a beat this cycle |
| in_data | input | 64 | Four halves, lane k at bits [16k+15:16k] |
| out_valid | output | 1 | Output register holds a converted word |
| out_ready | input | 1 | Consumer takes the output word this cycle |
| out_data | output | 32 | Four bytes, byte k at bits [8k+7:8k] |

## Verification
The lane-carry assertion presumes that every half it judges lies in scope, below 0x3FC0 in magnitude. It therefore looks only at known lanes that pass that test and makes no claim about the rest. The handshake assertions presume only that the consumer's `out_ready` is a known level at each edge. All data stimulus, including the exhaustive magnitude sweep and the carry stress patterns, is built from magnitudes no larger than 0x3FBF. The sign bits are varied freely, since the sign travels apart from the rounding path.

// File: rtl/f8cvt_pkg.sv
package f8cvt_pkg;
  // source format: sign | 5-bit exponent | 10-bit mantissa
  localparam int HALF_W      = 16;
  // target format: sign | 4-bit exponent | 3-bit mantissa
  localparam int OUT_W       = 8;
  localparam int OUT_MAG_W   = OUT_W - 1;
  // position of the rounding bit after the one-place left shift
  localparam int RND_POS     = HALF_W - OUT_W - 1;
  // magnitudes at or above this limit are outside the supported range
  localparam logic [HALF_W-2:0] SCOPE_LIMIT = 15'h3FC0;

  function automatic logic half_in_scope(input logic [HALF_W-1:0] h);
    return h[HALF_W-2:0] < SCOPE_LIMIT;
  endfunction
endpackage

// File: rtl/f8cvt_word_lanes.sv
module f8cvt_word_lanes
  import f8cvt_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic [LANES*HALF_W-1:0] word_i,
  output logic [LANES*OUT_W-1:0]  bytes_o
);
  localparam int WORD_W = LANES * HALF_W;

  logic [WORD_W-1:0] keep_mask;
  logic [WORD_W-1:0] round_add;
  logic [WORD_W-1:0] shifted;
  logic [WORD_W-1:0] summed;

  // One wide add rounds every lane; the masked-off lane top bit absorbs
  // any carry so it never reaches the next lane.
  assign shifted = (word_i << 1) & keep_mask;
  assign summed  = shifted + round_add;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam int BASE = l * HALF_W;
    logic lane_unused_bits;

    assign keep_mask[BASE +: HALF_W] = {1'b0, {(HALF_W-2){1'b1}}, 1'b0};
    assign round_add[BASE +: HALF_W] = HALF_W'(1) << RND_POS;
    assign bytes_o[l*OUT_W +: OUT_W] =
      {word_i[BASE + HALF_W - 1], summed[BASE + RND_POS + 1 +: OUT_MAG_W]};
    assign lane_unused_bits = ^{summed[BASE +: RND_POS + 1], summed[BASE + HALF_W - 1]};

    // R6: an in-scope lane never spills a carry into its guard bit
    always_comb begin
      if (!$isunknown(word_i[BASE +: HALF_W]) &&
          half_in_scope(word_i[BASE +: HALF_W])) begin
        assert_no_lane_carry_R6: assert (summed[BASE + HALF_W - 1] == 1'b0)
          else $error("lane %0d rounding carry reached guard bit", l);
      end
    end
  end
endmodule

// File: rtl/f8cvt_out_stage.sv
module f8cvt_out_stage #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] load_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic take;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (take) begin
        out_valid <= 1'b1;
        out_data  <= load_data;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  // R9: a stalled word stays put
  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)))
    else $error("output changed while stalled");

  // R8: no room is offered while a word is stalled
  assert_no_room_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready)
    else $error("ready raised while stalled");

  // R11: a taken beat shows up right after the edge
  assert_present_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid)
    else $error("accepted beat not presented");
endmodule

// File: rtl/half_to_f8_packer.sv
module half_to_f8_packer
  import f8cvt_pkg::*;
#(
  parameter int NUM_WORDS      = 2,
  parameter int LANES_PER_WORD = 2
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   in_valid,
  output logic                                   in_ready,
  input  logic [NUM_WORDS*LANES_PER_WORD*16-1:0] in_data,
  output logic                                   out_valid,
  input  logic                                   out_ready,
  output logic [NUM_WORDS*LANES_PER_WORD*8-1:0]  out_data
);
  localparam int WORD_W  = LANES_PER_WORD * HALF_W;
  localparam int WBYTE_W = LANES_PER_WORD * OUT_W;
  localparam int RES_W   = NUM_WORDS * WBYTE_W;

  logic [RES_W-1:0] converted;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    f8cvt_word_lanes #(.LANES(LANES_PER_WORD)) u_lanes (
      .word_i  (in_data[w*WORD_W +: WORD_W]),
      .bytes_o (converted[w*WBYTE_W +: WBYTE_W])
    );
  end

  f8cvt_out_stage #(.W(RES_W)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .load_data (converted),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
  );

  // R1: the sign of lane 0 arrives unchanged in byte 0
  assert_sign_carry_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_data[OUT_W-1] == $past(in_data[HALF_W-1])))
    else $error("lane 0 sign lost");
endmodule

// File: tb/half_to_f8_packer_test.sv
`timescale 1ns/1ps
module half_to_f8_packer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        out_ready = 1'b0;
  logic [63:0] in_data = '0;
  logic        in_ready;
  logic        out_valid;
  logic [31:0] out_data;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;
  longint mag_tab [128];

  half_to_f8_packer uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data)
  );

  always #2 clk = ~clk;

  // half magnitude scaled by 2^24, exact as an integer
  function automatic longint half_scaled(input logic [14:0] m);
    logic [4:0] e;
    logic [9:0] f;
    e = m[14:10];
    f = m[9:0];
    if (e == 0) return longint'(f);
    return longint'(1024 + f) << (e - 1);
  endfunction

  // nearest byte by exhaustive distance search; ties to larger magnitude
  function automatic logic [7:0] nearest_f8(input logic [15:0] h);
    longint v, d, best_d;
    int best;
    v = half_scaled(h[14:0]);
    best = 0;
    best_d = (v > mag_tab[0]) ? v - mag_tab[0] : mag_tab[0] - v;
    for (int c = 1; c < 128; c++) begin
      d = (v > mag_tab[c]) ? v - mag_tab[c] : mag_tab[c] - v;
      if (d <= best_d) begin
        best_d = d;
        best = c;
      end
    end
    return {h[15], 7'(best)};
  endfunction

  function automatic logic [31:0] expect4(input logic [63:0] d);
    return {nearest_f8(d[63:48]), nearest_f8(d[47:32]),
            nearest_f8(d[31:16]), nearest_f8(d[15:0])};
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic xfer(input logic [63:0] d, output logic [31:0] got);
    @(negedge clk);
    in_data   = d;
    in_valid  = 1'b1;
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    got = out_data;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10", "out_valid in reset", 32'(out_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10", "out_valid after reset", 32'(out_valid), 32'd0);
    chk("R8", "in_ready when empty", 32'(in_ready), 32'd1);
  endtask

  task automatic t_lane_order;
    logic [31:0] got;
    xfer({16'h0200, 16'h0180, 16'h0100, 16'h0080}, got);
    chk("R5", "lane order", got, 32'h04030201);
    xfer({16'h8000, 16'h3C00, 16'h0000, 16'hBC00}, got);
    chk("R5", "lane order signed", got, 32'h807800F8);
  endtask

  task automatic t_roundtrip;
    logic [31:0] got;
    logic [63:0] d;
    for (int b = 0; b < 256; b += 4) begin
      for (int k = 0; k < 4; k++) begin
        logic [7:0] c;
        c = 8'(b + k);
        d[16*k +: 16] = {c[7], 1'b0, c[6:0], 7'b0};
      end
      xfer(d, got);
      chk("R7", "round trip", got, {8'(b+3), 8'(b+2), 8'(b+1), 8'(b)});
      chk("R2", "exact slice", got & 32'h7F7F7F7F,
          {8'((b+3) & 8'h7F), 8'((b+2) & 8'h7F), 8'((b+1) & 8'h7F), 8'(b & 8'h7F)});
    end
  endtask

  task automatic t_sweep;
    logic [31:0] got;
    logic [63:0] d;
    for (int m = 0; m < 16320; m += 4) begin
      for (int k = 0; k < 4; k++)
        d[16*k +: 16] = {1'(k & 1), 15'(m + k)};
      xfer(d, got);
      chk("R3", "nearest magnitude", got, expect4(d));
      chk("R1", "sign bits", got & 32'h80808080, 32'h80008000);
    end
  endtask

  task automatic t_ties;
    logic [31:0] got;
    logic [15:0] h [4];
    logic [31:0] exp;
    h[0] = 16'h0040; h[1] = 16'h3C40; h[2] = 16'h3BC0; h[3] = 16'hBBC0;
    for (int k = 0; k < 4; k++)
      exp[8*k +: 8] = {h[k][15], 7'(h[k][13:7] + 7'd1)};
    xfer({h[3], h[2], h[1], h[0]}, got);
    chk("R4", "ties away from zero", got, exp);
  endtask

  task automatic t_isolation;
    logic [31:0] got;
    logic [63:0] d;
    d = {16'h8000, 16'hBFBF, 16'h0000, 16'h3FBF};
    xfer(d, got);
    chk("R6", "carry stress a", got, 32'h80FF007F);
    d = {16'hBFBF, 16'h0000, 16'h3FBF, 16'h8000};
    xfer(d, got);
    chk("R6", "carry stress b", got, 32'hFF007F80);
    d = {16'h3FBF, 16'h3FBF, 16'h3FBF, 16'h3FBF};
    xfer(d, got);
    chk("R6", "all lanes at top", got, 32'h7F7F7F7F);
  endtask

  task automatic t_backpressure;
    logic [63:0] a, b;
    a = {16'h0080, 16'h3C00, 16'h8100, 16'h2A5A};
    b = {16'hBB00, 16'h0001, 16'h1234, 16'h3F00};
    @(negedge clk);
    out_ready = 1'b0;
    in_data   = a;
    in_valid  = 1'b1;
    #0;
    chk("R8", "ready when empty", 32'(in_ready), 32'd1);
    @(negedge clk);
    chk("R11", "valid after take", 32'(out_valid), 32'd1);
    chk("R11", "data after take", out_data, expect4(a));
    chk("R8", "ready low while stalled", 32'(in_ready), 32'd0);
    in_data = b;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R9", "data held", out_data, expect4(a));
      chk("R9", "valid held", 32'(out_valid), 32'd1);
    end
    out_ready = 1'b1;
    #0;
    chk("R8", "ready with drain", 32'(in_ready), 32'd1);
    @(negedge clk);
    chk("R8", "second beat taken", out_data, expect4(b));
    in_valid = 1'b0;
    @(negedge clk);
    chk("R11", "valid falls after drain", 32'(out_valid), 32'd0);
  endtask

  initial begin
    for (int c = 0; c < 128; c++)
      mag_tab[c] = half_scaled({1'b0, 7'(c), 7'b0});
    t_reset();
    t_lane_order();
    t_roundtrip();
    t_ties();
    t_isolation();
    t_backpressure();
    t_sweep();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule